// File: doc/BRIEF.md
# Snapshot-Read System Timebase Counter

This block keeps two independent 52-bit tick counters that form a system timebase. Each counter advances by one on every cycle where the shared tick-enable input is high, its own run bit is set, and no processor core whose stall it honours is stalled. Software never reads a counter directly. It writes a one to a unit's capture bit, which copies the live count into a pair of snapshot words. It then polls a sticky valid bit before it reads the high (20-bit) and low (32-bit) halves. The two halves therefore always belong to the same instant.

Software can also preset a counter. It writes a 52-bit preset value as a 20-bit high word and a 32-bit low word, then writes a one to the unit's preset bit. All access goes through a simple strobed write port and a registered read port with one cycle of latency. A single control word holds every unit's run bit and its per-core stall enables.

Top module: `tbase_timer`

## Requirements
- R1: A unit's counter increases by exactly one at each clock edge where tick_en is high, the unit's run bit is set, and no core_stall bit whose enable is set for that unit is high. Otherwise the counter holds its value, unless it is preset.
- R2: Writing a word with bit 0 set to a unit's command register copies the live count, as it was before that edge, into the snapshot. The snapshot high word (bits 19:0, upper bits read 0) sits at unit offset 3, and the low word sits at offset 4.
- R3: The valid flag is command register bit 2. It clears at the edge that takes a capture request and reads one from the following edge onward. Writing bit 2 as one clears it, but a pending set wins over that clear. Command bits 0 and 1 always read zero.
- R4: The preset value is held at unit offsets 1 (high, bits 19:0 kept, the rest read 0) and 2 (low). Writing bit 1 of the command register copies it into the counter.
- R5: A preset in the same cycle as a tick replaces the increment. A capture in the same write as a preset records the pre-preset count.
- R6: The counter rolls from 2^52-1 to 0 with no other effect.
- R7: Control register (address 0) bit u is unit u's run bit. After reset it reads 0b110001: unit 0 runs, unit 1 is stopped. A stopped unit holds its count.
- R8: Control bit 2+2u+c enables unit u to pause while core_stall[c] is high. After reset, unit 1 honours both cores and unit 0 ignores both. A stall bit whose enable is clear has no effect.
- R9: The command register of unit u is at address 8+8u. Reads of unmapped addresses return zero. rd_data is updated one edge after rd_en and holds while rd_en is low. After reset, every register other than control reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count pulse shared by all units |
| core_stall | input | 2 | Stall indication from each processor core |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Read word address |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_en |

## Verification
The bench preloads a value three ticks below the top and captures across the roll-over. A design with a short carry or a saturating counter shows a wrong snapshot high word there. It issues a capture and a preset in a single write while ticking. A design that ordered them the other way would capture the preset value, and one that let the tick win would be off by one. It drives each core's stall with that core's enable first clear and then set. A design that ignored the enable, or that swapped the core or unit enable bits, would freeze or run the wrong counter. It also polls the valid flag cycle by cycle around a capture and a software clear, which exposes a flag that sets in the same cycle as the copy or that a clear can override.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int CNT_W       = 52;
    localparam int LO_W        = 32;
    localparam int HI_W        = CNT_W - LO_W;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 6;
    localparam int NUM_UNITS   = 2;
    localparam int NUM_CORES   = 2;
    localparam int CTRL_W      = NUM_UNITS + NUM_UNITS * NUM_CORES;

    // address map
    localparam int ADDR_CTRL   = 0;
    localparam int UNIT_BASE   = 8;
    localparam int UNIT_STRIDE = 8;
    localparam int OFS_CMD     = 0;
    localparam int OFS_LD_HI   = 1;
    localparam int OFS_LD_LO   = 2;
    localparam int OFS_SNAP_HI = 3;
    localparam int OFS_SNAP_LO = 4;

    // command register bits
    localparam int CMD_UPD     = 0;
    localparam int CMD_LD      = 1;
    localparam int CMD_VALID   = 2;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef enum logic [2:0] {
        UR_NONE,
        UR_CMD,
        UR_LD_HI,
        UR_LD_LO,
        UR_SNAP_HI,
        UR_SNAP_LO
    } ureg_e;

    typedef struct packed {
        logic  upd;
        logic  ld;
        logic  clr_valid;
        logic  wr_hi;
        logic  wr_lo;
        word_t data;
    } unit_wr_t;

    typedef struct packed {
        logic valid;
        cnt_t snap;
        cnt_t ldv;
    } unit_view_t;

    function automatic ureg_e unit_reg(addr_t a, int u);
        int ai;
        int base;
        ai   = int'(a);
        base = UNIT_BASE + u * UNIT_STRIDE;
        if (ai < base || ai >= base + UNIT_STRIDE) return UR_NONE;
        case (ai - base)
            OFS_CMD:     return UR_CMD;
            OFS_LD_HI:   return UR_LD_HI;
            OFS_LD_LO:   return UR_LD_LO;
            OFS_SNAP_HI: return UR_SNAP_HI;
            OFS_SNAP_LO: return UR_SNAP_LO;
            default:     return UR_NONE;
        endcase
    endfunction

    function automatic word_t hi_word(cnt_t v);
        return word_t'(v[CNT_W-1:LO_W]);
    endfunction

    function automatic word_t lo_word(cnt_t v);
        return word_t'(v[LO_W-1:0]);
    endfunction

    function automatic int sen_lsb(int u);
        return NUM_UNITS + u * NUM_CORES;
    endfunction

    // unit 0 runs and ignores stalls; the other units stop and honour all cores
    function automatic ctrl_t ctrl_reset();
        ctrl_t r;
        r = '0;
        r[0] = 1'b1;
        for (int u = 1; u < NUM_UNITS; u++) begin
            for (int c = 0; c < NUM_CORES; c++) begin
                r[sen_lsb(u) + c] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tbase_cnt_core.sv
module tbase_cnt_core
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic load,
    input  cnt_t load_val,
    output cnt_t cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + cnt_t'(1);
        end
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        inc && !load |=> cnt == $past(cnt) + cnt_t'(1));

    // R6
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        inc && !load && (&cnt) |=> cnt == '0);

    // R5
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc && !load |=> $stable(cnt));

endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  unit_wr_t   wr,
    input  logic       inc,
    output unit_view_t view
);

    cnt_t live;
    cnt_t snap_q;
    cnt_t ldv_q;
    logic valid_q;
    logic pend_q;

    tbase_cnt_core u_core (
        .clk      (clk),
        .rst      (rst),
        .inc      (inc),
        .load     (wr.ld),
        .load_val (ldv_q),
        .cnt      (live)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            ldv_q   <= '0;
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (wr.wr_hi) ldv_q[CNT_W-1:LO_W] <= wr.data[HI_W-1:0];
            if (wr.wr_lo) ldv_q[LO_W-1:0]     <= wr.data[LO_W-1:0];
            if (wr.upd)   snap_q              <= live;
            pend_q <= wr.upd;
            if (wr.upd) begin
                valid_q <= 1'b0;
            end else if (pend_q) begin
                valid_q <= 1'b1;
            end else if (wr.clr_valid) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign view = '{valid: valid_q, snap: snap_q, ldv: ldv_q};

    // R2
    snap_copy_chk: assert property (@(posedge clk) disable iff (rst)
        wr.upd |=> view.snap == $past(live));

    // R3
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        wr.upd |=> !view.valid);

    // R3
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(view.valid) |-> $past(wr.upd, 2));

endmodule

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
    import tbase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_ctrl,
    input  ctrl_t                wr_bits,
    input  logic                 tick_en,
    input  logic [NUM_CORES-1:0] core_stall,
    output ctrl_t                ctrl_q,
    output logic [NUM_UNITS-1:0] unit_inc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_reset();
        end else if (wr_ctrl) begin
            ctrl_q <= wr_bits;
        end
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_gate
        localparam int SEN_LSB = NUM_UNITS + u * NUM_CORES;
        logic [NUM_CORES-1:0] sen;
        logic                 blocked;
        assign sen         = ctrl_q[SEN_LSB +: NUM_CORES];
        assign blocked     = |(core_stall & sen);
        assign unit_inc[u] = tick_en & ctrl_q[u] & ~blocked;
    end

    // R8
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ctrl_q == $past(wr_bits));

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic [NUM_CORES-1:0] core_stall,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);

    ctrl_t                       ctrl_q;
    logic [NUM_UNITS-1:0]        unit_inc;
    logic                        wr_ctrl;
    unit_wr_t [NUM_UNITS-1:0]    uwr;
    unit_view_t [NUM_UNITS-1:0]  views;
    word_t                       rd_next;

    assign wr_ctrl = wr_en && (wr_addr == addr_t'(ADDR_CTRL));

    tbase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wr_bits    (wr_data[CTRL_W-1:0]),
        .tick_en    (tick_en),
        .core_stall (core_stall),
        .ctrl_q     (ctrl_q),
        .unit_inc   (unit_inc)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        ureg_e wsel;
        logic  cmd_hit;
        assign wsel    = unit_reg(wr_addr, u);
        assign cmd_hit = wr_en && (wsel == UR_CMD);
        assign uwr[u]  = '{
            upd:       cmd_hit && wr_data[CMD_UPD],
            ld:        cmd_hit && wr_data[CMD_LD],
            clr_valid: cmd_hit && wr_data[CMD_VALID],
            wr_hi:     wr_en && (wsel == UR_LD_HI),
            wr_lo:     wr_en && (wsel == UR_LD_LO),
            data:      wr_data
        };

        tbase_unit u_unit (
            .clk  (clk),
            .rst  (rst),
            .wr   (uwr[u]),
            .inc  (unit_inc[u]),
            .view (views[u])
        );
    end

    always_comb begin
        rd_next = '0;
        if (rd_addr == addr_t'(ADDR_CTRL)) begin
            rd_next = word_t'(ctrl_q);
        end
        for (int u = 0; u < NUM_UNITS; u++) begin
            case (unit_reg(rd_addr, u))
                UR_CMD:     rd_next[CMD_VALID] = views[u].valid;
                UR_LD_HI:   rd_next = hi_word(views[u].ldv);
                UR_LD_LO:   rd_next = lo_word(views[u].ldv);
                UR_SNAP_HI: rd_next = hi_word(views[u].snap);
                UR_SNAP_LO: rd_next = lo_word(views[u].snap);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    // R3
    rd_strobe_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && (unit_reg(rd_addr, 0) == UR_CMD) |=> rd_data[CMD_LD:CMD_UPD] == 2'b00);

    // R9
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && (rd_addr == addr_t'(1)) |=> rd_data == '0);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_tbase_timer.sv
module sim_tbase_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [1:0]  core_stall = 2'b00;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;

    always #4 clk = ~clk;

    tbase_timer u0 (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .core_stall (core_stall),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    // behavioural reference state
    logic [51:0] m_cnt  [2];
    logic [51:0] m_snap [2];
    logic [51:0] m_ldv  [2];
    bit          m_valid[2];
    bit          m_pend [2];
    logic [5:0]  m_ctrl;
    logic [31:0] exp_rd;
    logic [5:0]  last_ra;
    string       cur_req = "R7 reset";
    bit          chk_en = 1'b0;
    bit          done = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    function automatic logic [31:0] mread(input logic [5:0] a);
        if (a == 6'd0) return {26'b0, m_ctrl};
        for (int u = 0; u < 2; u++) begin
            int b = 8 + 8 * u;
            if (a == 6'(b))     return {29'b0, m_valid[u], 2'b00};
            if (a == 6'(b + 1)) return {12'b0, m_ldv[u][51:32]};
            if (a == 6'(b + 2)) return m_ldv[u][31:0];
            if (a == 6'(b + 3)) return {12'b0, m_snap[u][51:32]};
            if (a == 6'(b + 4)) return m_snap[u][31:0];
        end
        return 32'b0;
    endfunction

    task automatic step(input bit r, input bit we, input logic [5:0] wa,
                        input logic [31:0] wd, input logic [5:0] ra,
                        input bit tk, input logic [1:0] st);
        @(negedge clk);
        if (chk_en) begin
            n_chk++;
            if (rd_data !== exp_rd) begin
                n_fail++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", cur_req, last_ra, rd_data, exp_rd);
            end
        end
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = 1'b1; rd_addr = ra; tick_en = tk; core_stall = st;
        last_ra = ra;
        if (r) begin
            exp_rd = '0;
            m_ctrl = 6'b110001;  // R7, R8 reset values
            for (int u = 0; u < 2; u++) begin
                m_cnt[u] = '0; m_snap[u] = '0; m_ldv[u] = '0;
                m_valid[u] = 1'b0; m_pend[u] = 1'b0;
            end
        end else begin
            exp_rd = mread(ra);
            for (int u = 0; u < 2; u++) begin
                int  b   = 8 + 8 * u;
                bit  hit = we && (wa == 6'(b));
                bit  upd = hit && wd[0];
                bit  ld  = hit && wd[1];
                bit  clr = hit && wd[2];
                bit  inc = tk && m_ctrl[u] && !(|(st & m_ctrl[2 + 2 * u +: 2]));
                if (upd) m_valid[u] = 1'b0;
                else if (m_pend[u]) m_valid[u] = 1'b1;
                else if (clr) m_valid[u] = 1'b0;
                m_pend[u] = upd;
                if (upd) m_snap[u] = m_cnt[u];
                if (ld) m_cnt[u] = m_ldv[u];
                else if (inc) m_cnt[u] = m_cnt[u] + 52'd1;
                if (we && wa == 6'(b + 1)) m_ldv[u][51:32] = wd[19:0];
                if (we && wa == 6'(b + 2)) m_ldv[u][31:0] = wd;
            end
            if (we && wa == 6'd0) m_ctrl = wd[5:0];
        end
        chk_en = 1'b1;
    endtask

    task automatic idle(input int n, input bit tk, input logic [1:0] st, input logic [5:0] ra);
        for (int i = 0; i < n; i++) step(0, 0, 6'd0, 32'd0, ra, tk, st);
    endtask

    task automatic wr(input logic [5:0] wa, input logic [31:0] wd, input bit tk,
                      input logic [1:0] st, input logic [5:0] ra);
        step(0, 1, wa, wd, ra, tk, st);
    endtask

    task automatic capture_read(input int u, input bit tk, input logic [1:0] st);
        logic [5:0] b = 6'(8 + 8 * u);
        wr(b, 32'h1, tk, st, b);
        idle(1, tk, st, b);
        idle(1, tk, st, b);
        idle(1, tk, st, b + 6'd3);
        idle(1, tk, st, b + 6'd4);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(1, 0, 6'd0, 32'd0, 6'd0, 0, 2'b00);

        cur_req = "R7 reset control";
        idle(2, 0, 2'b00, 6'd0);
        cur_req = "R9 unmapped and reset reads";
        idle(1, 0, 2'b00, 6'd5);
        idle(1, 0, 2'b00, 6'd13);
        idle(1, 0, 2'b00, 6'd40);
        idle(1, 0, 2'b00, 6'd12);
        idle(1, 0, 2'b00, 6'd20);

        cur_req = "R1 ticking";
        idle(30, 1, 2'b00, 6'd8);
        for (int i = 0; i < 10; i++) idle(1, i[0], 2'b00, 6'd12);
        cur_req = "R2 capture";
        capture_read(0, 1, 2'b00);
        capture_read(0, 0, 2'b00);

        cur_req = "R3 valid clear";
        wr(6'd8, 32'h4, 1, 2'b00, 6'd8);
        idle(2, 1, 2'b00, 6'd8);
        wr(6'd8, 32'h1, 1, 2'b00, 6'd8);
        wr(6'd8, 32'h4, 1, 2'b00, 6'd8);
        idle(2, 0, 2'b00, 6'd8);

        cur_req = "R4 preset registers";
        wr(6'd9, 32'hABCF_FFFF, 0, 2'b00, 6'd9);
        wr(6'd10, 32'hFFFF_FFFD, 0, 2'b00, 6'd9);
        idle(1, 0, 2'b00, 6'd10);
        wr(6'd8, 32'h2, 0, 2'b00, 6'd8);
        cur_req = "R6 roll-over";
        for (int i = 0; i < 4; i++) begin
            idle(1, 1, 2'b00, 6'd8);
            capture_read(0, 0, 2'b00);
        end

        cur_req = "R5 preset versus tick and capture";
        wr(6'd9, 32'h0, 1, 2'b00, 6'd9);
        wr(6'd10, 32'h100, 1, 2'b00, 6'd10);
        wr(6'd8, 32'h3, 1, 2'b00, 6'd8);
        idle(2, 1, 2'b00, 6'd11);
        idle(1, 1, 2'b00, 6'd12);
        capture_read(0, 0, 2'b00);

        cur_req = "R8 stall ignored when disabled";
        idle(5, 1, 2'b11, 6'd8);
        capture_read(0, 1, 2'b11);
        cur_req = "R8 stall honoured";
        wr(6'd0, 32'h35, 0, 2'b00, 6'd0);
        idle(5, 1, 2'b01, 6'd0);
        capture_read(0, 1, 2'b01);
        idle(5, 1, 2'b10, 6'd8);
        capture_read(0, 1, 2'b10);

        cur_req = "R7 unit1 run and unit0 stop";
        capture_read(1, 1, 2'b00);
        wr(6'd0, 32'h32, 0, 2'b00, 6'd0);
        idle(6, 1, 2'b00, 6'd16);
        capture_read(1, 1, 2'b10);
        capture_read(0, 1, 2'b00);
        cur_req = "R8 unit1 stalls";
        idle(4, 1, 2'b10, 6'd16);
        capture_read(1, 1, 2'b01);
        capture_read(1, 1, 2'b00);

        cur_req = "R4 unit1 preset";
        wr(6'd17, 32'h0000_0ABC, 1, 2'b00, 6'd17);
        wr(6'd18, 32'h1234_5678, 1, 2'b00, 6'd18);
        wr(6'd16, 32'h2, 1, 2'b00, 6'd17);
        capture_read(1, 1, 2'b00);

        cur_req = "R9 random mix";
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] wa;
            logic [31:0] wd;
            case ($urandom_range(0, 6))
                0: wa = 6'd0;
                1: wa = 6'd8;
                2: wa = 6'd9;
                3: wa = 6'd10;
                4: wa = 6'd16;
                5: wa = 6'd17;
                default: wa = 6'd18;
            endcase
            wd = $urandom;
            if (wa == 6'd0 && $urandom_range(0, 3) != 0) wd[1:0] = 2'b11;
            step(0, $urandom_range(0, 3) == 0, wa, wd, 6'($urandom_range(0, 23)),
                 $urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)));
        end
        idle(1, 0, 2'b00, 6'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule